// File: doc/BRIEF.md
# Triangle Coverage Rasterizer

This block turns one screen-space triangle into the pixels it covers. When a start strobe arrives it takes three vertices with integer coordinates, forms the triangle's bounding box, and cuts that box to the screen size. It then visits every pixel of the box, one per cycle. Each covered pixel is offered on a valid/ready fragment port. A single-cycle done pulse marks the end of the triangle. Projection, clipping, attribute interpolation, depth, texture and memory access are all handled elsewhere.

The coverage test uses three edge functions. A fill rule admits pixels on top and left edges and rejects pixels on bottom and right edges. With this rule, a mesh of adjacent triangles draws each pixel on a shared edge exactly once. The edge values are set up once per triangle at the box origin. After that they are only stepped by addition. A triangle whose signed area is zero or negative is rejected at once, and so is a box that lies fully off screen.

Top module: `tri_coverage_raster`

## Requirements
- R1: After reset, and until a start strobe is accepted, frag_valid_o and done_o are low.
- R2: The edges are taken in the order v0→v1, v1→v2, v2→v0, with edge vector a = v_next − v_cur. An edge is top/left when a.y < 0, or when a.y = 0 and a.x < 0. Every other edge is bottom/right.
- R3: The edge function is E(p) = a.x·(p.y − v_cur.y) − a.y·(p.x − v_cur.x). A pixel (x, y) is covered when, on every edge, E > 0 or E = 0 with the edge top/left.
- R4: Take two anti-clockwise triangles that share an edge. Each pixel of their union is emitted by exactly one of them.
- R5: The fragments of one triangle leave in scan order: rows by ascending y starting at the box minimum, and inside a row by ascending x.
- R6: The box spans the vertex min/max, and its maxima are clamped to SCREEN_W−1 and SCREEN_H−1. No fragment lies outside the screen. A box whose minimum x or y is beyond the screen produces no fragments, and done_o is high in the cycle after start.
- R7: A triangle whose signed area (v1−v0)×(v2−v0) is ≤ 0 produces no fragments, and done_o is high in the cycle after start.
- R8: While frag_valid_o is high and frag_ready_i is low, the same fragment is held on the next cycle. No pixel is skipped or repeated.
- R9: done_o is a one-cycle pulse. The block visits one box pixel per cycle. With frag_ready_i held high and a box of N pixels, done_o is high N+1 cycles after the cycle in which start was sampled.
- R10: A start strobe that arrives while a triangle is being scanned has no effect on that triangle's fragments.
- R11: Vertex coordinates anywhere in 0 … 2^COORD_W−1 give correct coverage, with no arithmetic overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only while idle |
| vx_i | input | 3×COORD_W | Vertex x coordinates, index = vertex number |
| vy_i | input | 3×COORD_W | Vertex y coordinates, index = vertex number |
| frag_valid_o | output | 1 | A covered pixel is offered |
| frag_ready_i | input | 1 | The consumer accepts the offered pixel |
| frag_x_o | output | COORD_W | x of the offered pixel |
| frag_y_o | output | COORD_W | y of the offered pixel |
| done_o | output | 1 | One-cycle pulse when the triangle is finished |

## Verification
The hardest case to reach is a pixel that sits exactly on an edge, because there the answer depends only on the fill rule. Two pairs of triangles split a 4×4 square along its diagonals. Each pair puts many pixels on a shared edge and along axis-aligned top, bottom, left and right edges, and the bench checks that the union has no gaps and no overlaps. A second hard case is a stall that lands just as the scan wraps to a new row. A pseudo-random ready pattern on long, thin triangles makes stalls fall on row wraps and on pixels that are not covered.

// File: rtl/tri_raster_pkg.sv
package tri_raster_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_SCAN = 1'b1
    } walk_state_e;

endpackage

// File: rtl/tri_edge_setup.sv
module tri_edge_setup #(
    parameter int COORD_W = 6
) (
    input  logic [COORD_W-1:0]     xa_i,
    input  logic [COORD_W-1:0]     ya_i,
    input  logic [COORD_W-1:0]     xb_i,
    input  logic [COORD_W-1:0]     yb_i,
    input  logic [COORD_W-1:0]     ox_i,
    input  logic [COORD_W-1:0]     oy_i,
    output logic [2*COORD_W+2:0]   init_o,
    output logic [2*COORD_W+2:0]   step_x_o,
    output logic [2*COORD_W+2:0]   step_y_o,
    output logic                   top_left_o
);
    localparam int DW = COORD_W + 1;
    localparam int EW = 2 * COORD_W + 3;

    logic signed [DW-1:0] ax, ay, rx, ry;
    logic signed [EW-1:0] axw, ayw, rxw, ryw;

    // edge vector and origin offset, one sign bit wider than a coordinate
    assign ax = $signed({1'b0, xb_i}) - $signed({1'b0, xa_i});
    assign ay = $signed({1'b0, yb_i}) - $signed({1'b0, ya_i});
    assign rx = $signed({1'b0, ox_i}) - $signed({1'b0, xa_i});
    assign ry = $signed({1'b0, oy_i}) - $signed({1'b0, ya_i});

    assign axw = EW'(ax);
    assign ayw = EW'(ay);
    assign rxw = EW'(rx);
    assign ryw = EW'(ry);

    // value at the box origin, then the per-pixel and per-row increments
    assign init_o   = axw * ryw - ayw * rxw;
    assign step_x_o = -ayw;
    assign step_y_o = axw;

    assign top_left_o = ay[DW-1] || ((ay == '0) && ax[DW-1]);

endmodule

// File: rtl/tri_bbox.sv
module tri_bbox #(
    parameter int COORD_W  = 6,
    parameter int SCREEN_W = 48,
    parameter int SCREEN_H = 40
) (
    input  logic [2:0][COORD_W-1:0] vx_i,
    input  logic [2:0][COORD_W-1:0] vy_i,
    output logic [COORD_W-1:0]      x_lo_o,
    output logic [COORD_W-1:0]      x_hi_o,
    output logic [COORD_W-1:0]      y_lo_o,
    output logic [COORD_W-1:0]      y_hi_o,
    output logic                    empty_o
);
    localparam logic [COORD_W-1:0] XLIM = COORD_W'(SCREEN_W - 1);
    localparam logic [COORD_W-1:0] YLIM = COORD_W'(SCREEN_H - 1);

    logic [COORD_W-1:0] x_min, x_max, y_min, y_max;

    always_comb begin
        x_min = vx_i[0];
        x_max = vx_i[0];
        y_min = vy_i[0];
        y_max = vy_i[0];
        for (int i = 1; i < 3; i++) begin
            if (vx_i[i] < x_min) x_min = vx_i[i];
            if (vx_i[i] > x_max) x_max = vx_i[i];
            if (vy_i[i] < y_min) y_min = vy_i[i];
            if (vy_i[i] > y_max) y_max = vy_i[i];
        end
    end

    assign x_lo_o  = x_min;
    assign y_lo_o  = y_min;
    assign x_hi_o  = (x_max > XLIM) ? XLIM : x_max;
    assign y_hi_o  = (y_max > YLIM) ? YLIM : y_max;
    assign empty_o = (x_min > XLIM) || (y_min > YLIM);

endmodule

// File: rtl/tri_coverage_raster.sv
module tri_coverage_raster
    import tri_raster_pkg::*;
#(
    parameter int COORD_W  = 6,
    parameter int SCREEN_W = 48,
    parameter int SCREEN_H = 40
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [2:0][COORD_W-1:0] vx_i,
    input  logic [2:0][COORD_W-1:0] vy_i,
    output logic                    frag_valid_o,
    input  logic                    frag_ready_i,
    output logic [COORD_W-1:0]      frag_x_o,
    output logic [COORD_W-1:0]      frag_y_o,
    output logic                    done_o
);
    localparam int DW = COORD_W + 1;
    localparam int EW = 2 * COORD_W + 3;
    localparam logic [COORD_W-1:0] XLIM = COORD_W'(SCREEN_W - 1);
    localparam logic [COORD_W-1:0] YLIM = COORD_W'(SCREEN_H - 1);

    typedef struct packed {
        walk_state_e          st;
        logic                 done;
        logic [COORD_W-1:0]   x;
        logic [COORD_W-1:0]   y;
        logic [COORD_W-1:0]   x_lo;
        logic [COORD_W-1:0]   x_hi;
        logic [COORD_W-1:0]   y_hi;
        logic [2:0][EW-1:0]   ev;
        logic [2:0][EW-1:0]   row_ev;
        logic [2:0][EW-1:0]   sx;
        logic [2:0][EW-1:0]   sy;
        logic [2:0]           tl;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    // bounding box
    logic [COORD_W-1:0] bx_lo, bx_hi, by_lo, by_hi;
    logic               bb_empty;

    tri_bbox #(
        .COORD_W (COORD_W),
        .SCREEN_W(SCREEN_W),
        .SCREEN_H(SCREEN_H)
    ) u_bbox (
        .vx_i   (vx_i),
        .vy_i   (vy_i),
        .x_lo_o (bx_lo),
        .x_hi_o (bx_hi),
        .y_lo_o (by_lo),
        .y_hi_o (by_hi),
        .empty_o(bb_empty)
    );

    // per-edge setup at the box origin
    logic [2:0][EW-1:0] e_init, e_stx, e_sty;
    logic [2:0]         e_tl;

    for (genvar g = 0; g < 3; g++) begin : g_edge
        localparam int NX = (g == 2) ? 0 : g + 1;
        tri_edge_setup #(
            .COORD_W(COORD_W)
        ) u_edge (
            .xa_i      (vx_i[g]),
            .ya_i      (vy_i[g]),
            .xb_i      (vx_i[NX]),
            .yb_i      (vy_i[NX]),
            .ox_i      (bx_lo),
            .oy_i      (by_lo),
            .init_o    (e_init[g]),
            .step_x_o  (e_stx[g]),
            .step_y_o  (e_sty[g]),
            .top_left_o(e_tl[g])
        );
    end

    // signed doubled area decides winding and degeneracy
    logic signed [DW-1:0] d1x, d1y, d2x, d2y;
    logic signed [EW-1:0] area;
    logic                 area_pos;

    assign d1x = $signed({1'b0, vx_i[1]}) - $signed({1'b0, vx_i[0]});
    assign d1y = $signed({1'b0, vy_i[1]}) - $signed({1'b0, vy_i[0]});
    assign d2x = $signed({1'b0, vx_i[2]}) - $signed({1'b0, vx_i[0]});
    assign d2y = $signed({1'b0, vy_i[2]}) - $signed({1'b0, vy_i[0]});
    assign area = EW'(d1x) * EW'(d2y) - EW'(d1y) * EW'(d2x);
    assign area_pos = !area[EW-1] && (area != '0);

    // coverage of the current scan position
    logic [2:0] edge_ok;
    logic       covered;
    logic       advance;

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            edge_ok[i] = (!walk_q.ev[i][EW-1] && (walk_q.ev[i] != '0)) ||
                         ((walk_q.ev[i] == '0) && walk_q.tl[i]);
        end
    end

    assign covered = &edge_ok;
    assign advance = (walk_q.st == WALK_SCAN) && (!covered || frag_ready_i);

    // next state
    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        unique case (walk_q.st)
            WALK_IDLE: begin
                if (start_i) begin
                    if (bb_empty || !area_pos) begin
                        walk_d.done = 1'b1;
                    end else begin
                        walk_d.st   = WALK_SCAN;
                        walk_d.x    = bx_lo;
                        walk_d.y    = by_lo;
                        walk_d.x_lo = bx_lo;
                        walk_d.x_hi = bx_hi;
                        walk_d.y_hi = by_hi;
                        walk_d.tl   = e_tl;
                        for (int i = 0; i < 3; i++) begin
                            walk_d.ev[i]     = e_init[i];
                            walk_d.row_ev[i] = e_init[i];
                            walk_d.sx[i]     = e_stx[i];
                            walk_d.sy[i]     = e_sty[i];
                        end
                    end
                end
            end
            WALK_SCAN: begin
                if (advance) begin
                    if (walk_q.x == walk_q.x_hi) begin
                        if (walk_q.y == walk_q.y_hi) begin
                            walk_d.st   = WALK_IDLE;
                            walk_d.done = 1'b1;
                        end else begin
                            walk_d.y = walk_q.y + 1'b1;
                            walk_d.x = walk_q.x_lo;
                            for (int i = 0; i < 3; i++) begin
                                walk_d.row_ev[i] = walk_q.row_ev[i] + walk_q.sy[i];
                                walk_d.ev[i]     = walk_q.row_ev[i] + walk_q.sy[i];
                            end
                        end
                    end else begin
                        walk_d.x = walk_q.x + 1'b1;
                        for (int i = 0; i < 3; i++) begin
                            walk_d.ev[i] = walk_q.ev[i] + walk_q.sx[i];
                        end
                    end
                end
            end
            default: walk_d = walk_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign frag_valid_o = (walk_q.st == WALK_SCAN) && covered;
    assign frag_x_o     = walk_q.x;
    assign frag_y_o     = walk_q.y;
    assign done_o       = walk_q.done;

    // checks on the scan and handshake
    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frag_valid_o && !frag_ready_i |=> frag_valid_o && $stable(frag_x_o) && $stable(frag_y_o)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9

    AST_REJECT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (walk_q.st == WALK_IDLE) && start_i && !area_pos |=> done_o && !frag_valid_o); // R7

    AST_FRAG_ON_SCREEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frag_valid_o |-> (frag_x_o <= XLIM) && (frag_y_o <= YLIM)); // R6

    AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        advance && (walk_q.x != walk_q.x_hi) |=> frag_x_o == $past(frag_x_o) + 1'b1); // R5

    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (walk_q.st == WALK_SCAN) && start_i && !advance
        |=> $stable(frag_x_o) && $stable(frag_y_o)); // R10

endmodule

// File: tb/tri_coverage_raster_tb.sv
module tri_coverage_raster_tb;

    localparam int CW = 6;
    localparam int SW = 48;
    localparam int SH = 40;
    localparam int NT = 8;

    // x0,y0,x1,y1,x2,y2, hand-counted fragments (-1 = model only), stalls
    localparam int TBL [NT][8] = '{
        '{ 0,  0,  4,  0,  0,  4,    6, 0},
        '{ 4,  0,  4,  4,  0,  4,   10, 1},
        '{ 0,  0,  2,  2,  4,  4,    0, 0},
        '{ 0,  0,  0,  4,  4,  0,    0, 0},
        '{50,  0, 60,  0, 50, 10,    0, 0},
        '{ 0,  0, 63,  0,  0, 63, 1572, 0},
        '{ 1,  1,  6,  3,  1,  5,   -1, 1},
        '{10, 20, 30,  5, 40, 35,   -1, 1}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [2:0][CW-1:0]  vx = '0;
    logic [2:0][CW-1:0]  vy = '0;
    logic                frag_valid;
    logic                frag_ready = 1'b1;
    logic [CW-1:0]       frag_x, frag_y;
    logic                done;

    tri_coverage_raster #(
        .COORD_W (CW),
        .SCREEN_W(SW),
        .SCREEN_H(SH)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .vx_i        (vx),
        .vy_i        (vy),
        .frag_valid_o(frag_valid),
        .frag_ready_i(frag_ready),
        .frag_x_o    (frag_x),
        .frag_y_o    (frag_y),
        .done_o      (done)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int tx [3];
    int ty [3];
    int exp_x [SW*SH];
    int exp_y [SW*SH];
    int n_exp, exp_cycles;
    bit hit [SW][SH];
    int got_n, order_err, stall_err, dbl, done_cyc, done_late;
    int first_bad_x, first_bad_y;
    logic [7:0] lfsr = 8'hA5;

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: cycles %0d expected below %0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic bit is_tl(int i);
        int n = (i == 2) ? 0 : i + 1;
        int ax = tx[n] - tx[i];
        int ay = ty[n] - ty[i];
        return (ay < 0) || (ay == 0 && ax < 0);
    endfunction

    function automatic bit covers(int px, int py);
        for (int i = 0; i < 3; i++) begin
            int n = (i == 2) ? 0 : i + 1;
            int e = (tx[n] - tx[i]) * (py - ty[i]) - (ty[n] - ty[i]) * (px - tx[i]);
            if (!(e > 0 || (e == 0 && is_tl(i)))) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic build_expected();
        int xlo, xhi, ylo, yhi, area;
        bit empty;
        xlo = tx[0]; xhi = tx[0]; ylo = ty[0]; yhi = ty[0];
        for (int i = 1; i < 3; i++) begin
            if (tx[i] < xlo) xlo = tx[i];
            if (tx[i] > xhi) xhi = tx[i];
            if (ty[i] < ylo) ylo = ty[i];
            if (ty[i] > yhi) yhi = ty[i];
        end
        if (xhi > SW - 1) xhi = SW - 1;
        if (yhi > SH - 1) yhi = SH - 1;
        empty = (xlo > SW - 1) || (ylo > SH - 1);
        area = (tx[1] - tx[0]) * (ty[2] - ty[0]) - (ty[1] - ty[0]) * (tx[2] - tx[0]);
        n_exp = 0;
        if (empty || area <= 0) begin
            exp_cycles = 1;
        end else begin
            exp_cycles = (xhi - xlo + 1) * (yhi - ylo + 1) + 1;
            for (int y = ylo; y <= yhi; y++) begin
                for (int x = xlo; x <= xhi; x++) begin
                    if (covers(x, y)) begin
                        exp_x[n_exp] = x;
                        exp_y[n_exp] = y;
                        n_exp++;
                    end
                end
            end
        end
    endtask

    task automatic load(input int a0, input int b0, input int a1, input int b1,
                        input int a2, input int b2);
        tx[0] = a0; ty[0] = b0; tx[1] = a1; ty[1] = b1; tx[2] = a2; ty[2] = b2;
        build_expected();
    endtask

    // runs the loaded triangle; inject pulses a second start mid-scan
    task automatic run_tri(input bit stalls, input bit inject);
        int c = 0;
        bit prev_stall = 1'b0;
        int px = 0, py = 0;
        got_n = 0; order_err = 0; stall_err = 0; done_cyc = -1; done_late = 0;
        first_bad_x = -1; first_bad_y = -1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            vx[i] = CW'(tx[i]);
            vy[i] = CW'(ty[i]);
        end
        start = 1'b1;
        frag_ready = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            c++;
            start = 1'b0;
            if (inject && c == 3) begin
                start = 1'b1;
                vx[0] = 6'd0; vy[0] = 6'd0; vx[1] = 6'd4; vy[1] = 6'd0;
                vx[2] = 6'd0; vy[2] = 6'd4;
            end
            if (prev_stall) begin
                if (!(frag_valid && int'(frag_x) == px && int'(frag_y) == py)) stall_err++;
            end
            if (done) begin
                done_cyc = c;
                break;
            end
            if (c > 8000) break;
            if (stalls) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                frag_ready = lfsr[0] | lfsr[2];
            end else begin
                frag_ready = 1'b1;
            end
            prev_stall = frag_valid && !frag_ready;
            px = int'(frag_x);
            py = int'(frag_y);
            if (frag_valid && frag_ready) begin
                if (got_n >= n_exp || exp_x[got_n] != px || exp_y[got_n] != py) begin
                    if (order_err == 0) begin
                        first_bad_x = px;
                        first_bad_y = py;
                    end
                    order_err++;
                end
                if (px < SW && py < SH) begin
                    if (hit[px][py]) dbl++;
                    hit[px][py] = 1'b1;
                end
                got_n++;
            end
        end
        @(negedge clk);
        if (done) done_late = 1;
        frag_ready = 1'b1;
    endtask

    task automatic clear_map();
        for (int x = 0; x < SW; x++)
            for (int y = 0; y < SH; y++)
                hit[x][y] = 1'b0;
        dbl = 0;
    endtask

    function automatic int map_count();
        int n = 0;
        for (int x = 0; x < SW; x++)
            for (int y = 0; y < SH; y++)
                if (hit[x][y]) n++;
        return n;
    endfunction

    task automatic common_checks(input bit stalls);
        check(got_n == n_exp, "R3", "fragment count vs coverage rule", got_n, n_exp);
        check(order_err == 0, "R5", "fragment order/coords mismatches (first x)",
              first_bad_x, -1);
        check(done_late == 0, "R9", "done longer than one cycle", done_late, 0);
        if (!stalls)
            check(done_cyc == exp_cycles, "R9", "cycles from start to done",
                  done_cyc, exp_cycles);
        else
            check(stall_err == 0, "R8", "stall hold violations", stall_err, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(frag_valid == 1'b0, "R1", "valid in reset", int'(frag_valid), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(frag_valid == 1'b0 && done == 1'b0, "R1", "outputs idle after reset",
              int'(frag_valid) + int'(done), 0);

        // vector table
        for (int k = 0; k < NT; k++) begin
            load(TBL[k][0], TBL[k][1], TBL[k][2], TBL[k][3], TBL[k][4], TBL[k][5]);
            clear_map();
            run_tri(TBL[k][7] != 0, k == 5);
            common_checks(TBL[k][7] != 0);
            if (TBL[k][6] >= 0)
                check(got_n == TBL[k][6], "R2", "hand-counted fragments", got_n, TBL[k][6]);
            if (k == 2 || k == 3)
                check(got_n == 0 && done_cyc == 1, "R7", "reject: fragments+done cycle",
                      got_n * 100 + done_cyc, 1);
            if (k == 4)
                check(got_n == 0 && done_cyc == 1, "R6", "off-screen: fragments+done cycle",
                      got_n * 100 + done_cyc, 1);
            if (k == 5) begin
                check(got_n == 1572, "R11", "full-range triangle fragments", got_n, 1572);
                check(order_err == 0, "R10", "mid-scan start disturbed fragments",
                      order_err, 0);
                check(map_count() == got_n, "R6", "distinct on-screen fragments",
                      map_count(), got_n);
            end
        end

        // R4: pairs sharing a diagonal
        clear_map();
        load(0, 0, 4, 0, 0, 4); run_tri(1'b0, 1'b0);
        load(4, 0, 4, 4, 0, 4); run_tri(1'b1, 1'b0);
        check(dbl == 0, "R4", "pixels drawn twice (pair A)", dbl, 0);
        check(map_count() == 16, "R4", "union size (pair A)", map_count(), 16);
        clear_map();
        load(0, 0, 4, 0, 4, 4); run_tri(1'b0, 1'b0);
        common_checks(1'b0);
        load(0, 0, 4, 4, 0, 4); run_tri(1'b1, 1'b0);
        common_checks(1'b1);
        check(dbl == 0, "R4", "pixels drawn twice (pair B)", dbl, 0);
        check(map_count() == 16, "R4", "union size (pair B)", map_count(), 16);

        // R1: reset in the middle of a scan
        @(negedge clk);
        vx[0] = 6'd0; vy[0] = 6'd0; vx[1] = 6'd40; vy[1] = 6'd0;
        vx[2] = 6'd0; vy[2] = 6'd30;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(frag_valid == 1'b0 && done == 1'b0, "R1", "outputs after mid-scan reset",
              int'(frag_valid) + int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(frag_valid == 1'b0 && done == 1'b0, "R1", "idle after reset release",
              int'(frag_valid) + int'(done), 0);

        // recovery after reset
        clear_map();
        load(0, 0, 4, 0, 0, 4); run_tri(1'b0, 1'b0);
        common_checks(1'b0);

        summary();
        $finish;
    end

endmodule